// File: doc/BRIEF.md
# Programmable Bus Chip-Select Channel

This block is a single chip-select channel for an asynchronous 68k-style bus. Software loads three small registers through a plain write port: a base register that holds the matching address and block size, an option register that holds the cycle qualifiers and the termination behaviour, and a pin configuration that enables the channel and sets the width of the attached port.

On every bus cycle the channel checks the live address, function code, read/write line, transfer size and, for interrupt acknowledge cycles, the interrupt level against the active configuration. When all checks pass, it pulls an active-low strobe low. The strobe can follow the address strobe (or data strobe) directly, or it can be aligned to an E-clock edge. In asynchronous mode the channel can end the cycle itself with an internal DSACK after a programmed number of wait states. On interrupt acknowledge it can request autovectoring instead.

Top module: `cs_channel`

## Requirements
- R1: After reset cs_n_o = 1, dsack_n_o = 2'b11 and avec_n_o = 1. All registers read as zero, so the channel is disabled.
- R2: The pin configuration enables the channel only when it is 2'b10 (8-bit port) or 2'b11 (16-bit port). Any other value keeps all three outputs negated whatever the bus does.
- R3: Outside CPU space the channel compares addr_i[23:11] with the 13-bit base field. Block-size code 0..7 selects 2K, 8K, 16K, 64K, 128K, 256K, 512K or 1M. The low 0, 2, 3, 5, 6, 7, 8 or 9 bits of that field are left out of the comparison.
- R4: The space field works on fc_i as follows: 2'b00 accepts fc 7 (CPU space), 2'b01 accepts fc 1 or 2, 2'b10 accepts fc 5 or 6, and 2'b11 accepts fc 1, 2, 5 or 6. In the read/write field, bit 0 allows reads (rw_i = 1) and bit 1 allows writes.
- R5: On a 16-bit port, the upper lane is active when addr_i[0] = 0. The lower lane is active when addr_i[0] = 1 or siz_i ≠ 2'b01. The lane field enables the lower lane with bit 0 and the upper lane with bit 1, and the channel matches only if an active lane is enabled. On an 8-bit port the lane field is ignored.
- R6: With space 2'b00, a cycle matches only when it is an interrupt acknowledge (fc_i = 7 and addr_i[19:4] all ones). Its level addr_i[3:1] must equal the IPL field, unless that field is 3'b000, which accepts any level. In this case no base comparison is made.
- R7: In asynchronous mode cs_n_o is low in the same cycle as as_n_i, without waiting for a clock edge. If the strobe-select bit is set, ds_n_i must also be low. cs_n_o returns high in the cycle as_n_i returns high.
- R8: In synchronous mode cs_n_o goes low one clock after the first clock edge at which eclk_i is sampled high, having been low at the edge before, while as_n_i is low. It negates with as_n_i. No internal DSACK is produced in this mode.
- R9: In asynchronous mode the DSACK field controls termination. A value n in 0..13 pulls dsack_n_o low once n+1 clock edges have sampled as_n_i low. The value 14 pulls it low together with cs_n_o, and 15 never drives it. The asserted value is 2'b01 for a 16-bit port and 2'b10 for an 8-bit port. It returns to 2'b11 with as_n_i.
- R10: If the autovector bit is set and a matched cycle is an interrupt acknowledge, avec_n_o goes low together with cs_n_o and dsack_n_o stays 2'b11. On any other matched cycle avec_n_o stays high.
- R11: A register write becomes active only at a clock edge where as_n_i is high. A write made while as_n_i is low has no effect on the cycle in progress.
- R12: Register map by reg_sel_i:
  - 0 is the base register: {addr[23:11], block code[2:0]}.
  - 1 is the option register: [15:12] DSACK, [11] autovector, [10:8] IPL, [7:6] space, [5:4] read/write, [3:2] lane, [1] strobe select (1 = also wait for ds_n_i), [0] synchronous.
  - 2 is the pin configuration in wdata[1:0].
  - 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 16 | Register write data |
| as_n_i | input | 1 | Address strobe, active low |
| ds_n_i | input | 1 | Data strobe, active low |
| eclk_i | input | 1 | E-clock for synchronous mode |
| rw_i | input | 1 | 1 = read, 0 = write |
| fc_i | input | 3 | Function code |
| addr_i | input | 24 | Bus address |
| siz_i | input | 2 | Transfer size (2'b01 = byte) |
| cs_n_o | output | 1 | Chip-select strobe, active low |
| dsack_n_o | output | 2 | Internal DSACK, active low |
| avec_n_o | output | 1 | Autovector request, active low |

## Verification
An active configuration that is stale, or that changes in mid-cycle, shows up on cs_n_o in the very cycle as_n_i falls, because the strobe is purely combinational in asynchronous mode. A wait-state counter that does not clear, or is off by one, moves the falling edge of dsack_n_o by whole clock cycles. For that reason it is sampled once per cycle around the programmed count. A stuck synchronous flag shows as a strobe that arrives before the E-clock edge or never arrives at all. This is visible within one clock of the eclk_i rise.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int ADDR_W  = 24;
  localparam int BLK_LSB = 11;
  localparam int BASE_W  = ADDR_W - BLK_LSB;
  localparam int BLK_W   = 3;
  localparam int REG_W   = BASE_W + BLK_W;
  localparam int FC_W    = 3;
  localparam int WAIT_W  = 4;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_OPT  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [BASE_W-1:0] addr;
    logic [BLK_W-1:0]  blk;
  } base_t;

  typedef struct packed {
    logic [WAIT_W-1:0] dsack;
    logic              avec;
    logic [2:0]        ipl;
    logic [1:0]        space;
    logic [1:0]        rw;
    logic [1:0]        lane;
    logic              strb_ds;
    logic              sync;
  } opt_t;

  typedef struct packed {
    base_t      base;
    opt_t       opt;
    logic [1:0] pin;
  } cfg_t;

  // number of base-field bits left out of the compare for a block code
  function automatic logic [3:0] blk_mask_bits(logic [BLK_W-1:0] code);
    case (code)
      3'd0:    return 4'd0;
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd5;
      3'd4:    return 4'd6;
      3'd5:    return 4'd7;
      3'd6:    return 4'd8;
      default: return 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/cs_regs.sv
module cs_regs
  import cs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             as_n_i,
  output cfg_t             act_o
);
  cfg_t stage_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (we_i) begin
        case (reg_sel_e'(sel_i))
          SEL_BASE: stage_q.base <= base_t'(wdata_i);
          SEL_OPT:  stage_q.opt  <= opt_t'(wdata_i);
          SEL_PIN:  stage_q.pin  <= wdata_i[1:0];
          default:  ;
        endcase
      end
      // staged values go live only between bus cycles
      if (as_n_i) act_q <= stage_q;
    end
  end

  assign act_o = act_q;

  // R11
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_n_i |=> $stable(act_q));
endmodule

// File: rtl/cs_match.sv
module cs_match
  import cs_pkg::*;
(
  input  base_t             base_i,
  input  logic [1:0]        space_i,
  input  logic [1:0]        rw_en_i,
  input  logic [1:0]        lane_en_i,
  input  logic [2:0]        ipl_i,
  input  logic [1:0]        pin_i,
  input  logic [FC_W-1:0]   fc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  input  logic [1:0]        siz_i,
  output logic              hit_o,
  output logic              iack_o
);
  logic              space_hit, rw_hit, lane_hit, addr_hit, ipl_hit, cpu_sel;
  logic              upper_act, lower_act, data_fc;
  logic [BASE_W-1:0] keep_mask;

  always_comb begin
    data_fc = fc_i[1] ^ fc_i[0];
    case (space_i)
      2'b00:   space_hit = (fc_i == 3'd7);
      2'b01:   space_hit = !fc_i[2] && data_fc;
      2'b10:   space_hit = fc_i[2] && data_fc;
      default: space_hit = data_fc;
    endcase
    cpu_sel = (space_i == 2'b00);
    iack_o  = (fc_i == 3'd7) && (&addr_i[19:4]);
    ipl_hit = (ipl_i == 3'd0) || (ipl_i == addr_i[3:1]);

    keep_mask = {BASE_W{1'b1}} << blk_mask_bits(base_i.blk);
    addr_hit  = ((addr_i[ADDR_W-1:BLK_LSB] ^ base_i.addr) & keep_mask) == '0;

    rw_hit = rw_i ? rw_en_i[0] : rw_en_i[1];

    upper_act = !addr_i[0];
    lower_act = addr_i[0] || (siz_i != 2'b01);
    lane_hit  = pin_i[0] ? ((lane_en_i[1] && upper_act) || (lane_en_i[0] && lower_act))
                         : 1'b1;

    hit_o = pin_i[1] && space_hit && rw_hit && lane_hit &&
            (cpu_sel ? (iack_o && ipl_hit) : addr_hit);
  end
endmodule

// File: rtl/cs_term.sv
module cs_term
  import cs_pkg::*;
#(
  parameter int CNT_W = WAIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             iack_i,
  input  logic             as_n_i,
  input  logic             ds_n_i,
  input  logic             eclk_i,
  input  logic             sync_i,
  input  logic             strb_ds_i,
  input  logic             avec_en_i,
  input  logic             port16_i,
  input  logic [CNT_W-1:0] dsack_sel_i,
  output logic             cs_n_o,
  output logic [1:0]       dsack_n_o,
  output logic             avec_n_o
);
  localparam logic [CNT_W-1:0] SEL_EXT  = '1;
  localparam logic [CNT_W-1:0] SEL_FAST = SEL_EXT - 1'b1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic             eclk_q, sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             strobe_ok, cs_on, av_on, wait_done, dsk_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eclk_q <= 1'b0;
      sync_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      eclk_q <= eclk_i;
      if (as_n_i) begin
        sync_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        if (hit_i && sync_i && eclk_i && !eclk_q) sync_q <= 1'b1;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    strobe_ok = !as_n_i && (!strb_ds_i || !ds_n_i);
    cs_on     = hit_i && (sync_i ? (sync_q && !as_n_i) : strobe_ok);
    av_on     = cs_on && iack_i && avec_en_i;
    wait_done = (dsack_sel_i == SEL_FAST) ||
                ((dsack_sel_i != SEL_EXT) && (cnt_q > dsack_sel_i));
    dsk_on    = cs_on && !sync_i && !av_on && wait_done;
  end

  assign cs_n_o    = !cs_on;
  assign avec_n_o  = !av_on;
  assign dsack_n_o = dsk_on ? (port16_i ? 2'b01 : 2'b10) : 2'b11;

  // R9
  dsack_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsack_n_o != 2'b00);
  // R9
  dsack_with_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsack_n_o != 2'b11) |-> !cs_n_o);
  // R10
  avec_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avec_n_o |-> (dsack_n_o == 2'b11) && !cs_n_o);
  // R8
  sync_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !as_n_i && $past(as_n_i)) |-> cs_n_o);
endmodule

// File: rtl/cs_channel.sv
module cs_channel
  import cs_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_sel_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  input  logic                as_n_i,
  input  logic                ds_n_i,
  input  logic                eclk_i,
  input  logic                rw_i,
  input  logic [FC_W-1:0]     fc_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          siz_i,
  output logic                cs_n_o,
  output logic [1:0]          dsack_n_o,
  output logic                avec_n_o
);
  cfg_t act;
  logic hit, iack;

  cs_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .as_n_i  (as_n_i),
    .act_o   (act)
  );

  cs_match u_match (
    .base_i    (act.base),
    .space_i   (act.opt.space),
    .rw_en_i   (act.opt.rw),
    .lane_en_i (act.opt.lane),
    .ipl_i     (act.opt.ipl),
    .pin_i     (act.pin),
    .fc_i      (fc_i),
    .addr_i    (addr_i),
    .rw_i      (rw_i),
    .siz_i     (siz_i),
    .hit_o     (hit),
    .iack_o    (iack)
  );

  cs_term #(.CNT_W(WAIT_W)) u_term (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .iack_i      (iack),
    .as_n_i      (as_n_i),
    .ds_n_i      (ds_n_i),
    .eclk_i      (eclk_i),
    .sync_i      (act.opt.sync),
    .strb_ds_i   (act.opt.strb_ds),
    .avec_en_i   (act.opt.avec),
    .port16_i    (act.pin[0]),
    .dsack_sel_i (act.opt.dsack),
    .cs_n_o      (cs_n_o),
    .dsack_n_o   (dsack_n_o),
    .avec_n_o    (avec_n_o)
  );

  // R7
  cs_needs_as_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> !as_n_i);
  // R2
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act.pin[1] |-> cs_n_o && avec_n_o && (dsack_n_o == 2'b11));
endmodule

// File: tb/tb_cs_channel.sv
module tb_cs_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        as_n = 1'b1, ds_n = 1'b1, eclk = 1'b0, rw = 1'b1;
  logic [2:0]  fc = '0;
  logic [23:0] addr = '0;
  logic [1:0]  siz = 2'b01;
  logic        cs_n, avec_n;
  logic [1:0]  dsack_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  cs_channel dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .as_n_i(as_n), .ds_n_i(ds_n), .eclk_i(eclk),
    .rw_i(rw), .fc_i(fc), .addr_i(addr), .siz_i(siz),
    .cs_n_o(cs_n), .dsack_n_o(dsack_n), .avec_n_o(avec_n)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  pin;
    logic [15:0] base;
    logic [15:0] opt;
    logic [2:0]  fc;
    logic [23:0] addr;
    logic        rw;
    logic [1:0]  siz;
    logic        cs_n;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t VECS [NVEC] = '{
    '{4'd3, 2'b10, 16'h1203, 16'hF0FC, 3'd5, 24'h12ABCD, 1'b1, 2'b01, 1'b0}, // R3 64K inside
    '{4'd3, 2'b10, 16'h1203, 16'hF0FC, 3'd5, 24'h130000, 1'b1, 2'b01, 1'b1}, // R3 64K outside
    '{4'd3, 2'b10, 16'h1200, 16'hF0FC, 3'd5, 24'h120800, 1'b1, 2'b01, 1'b1}, // R3 2K outside
    '{4'd3, 2'b10, 16'h1200, 16'hF0FC, 3'd5, 24'h1207FF, 1'b1, 2'b01, 1'b0}, // R3 2K top
    '{4'd3, 2'b10, 16'h1207, 16'hF0FC, 3'd5, 24'h1FFFFE, 1'b1, 2'b01, 1'b0}, // R3 1M inside
    '{4'd3, 2'b10, 16'h1207, 16'hF0FC, 3'd5, 24'h200000, 1'b1, 2'b01, 1'b1}, // R3 1M outside
    '{4'd4, 2'b10, 16'h1203, 16'hF0BC, 3'd1, 24'h120000, 1'b1, 2'b01, 1'b1}, // R4 sup-only, user fc
    '{4'd4, 2'b10, 16'h1203, 16'hF0BC, 3'd6, 24'h120000, 1'b1, 2'b01, 1'b0}, // R4 sup-only, sup fc
    '{4'd4, 2'b10, 16'h1203, 16'hF07C, 3'd2, 24'h120000, 1'b1, 2'b01, 1'b0}, // R4 user-only, user fc
    '{4'd4, 2'b10, 16'h1203, 16'hF07C, 3'd5, 24'h120000, 1'b1, 2'b01, 1'b1}, // R4 user-only, sup fc
    '{4'd4, 2'b10, 16'h1203, 16'hF0DC, 3'd5, 24'h120000, 1'b0, 2'b01, 1'b1}, // R4 read-only, write
    '{4'd4, 2'b10, 16'h1203, 16'hF0DC, 3'd5, 24'h120000, 1'b1, 2'b01, 1'b0}, // R4 read-only, read
    '{4'd5, 2'b11, 16'h1203, 16'hF0F4, 3'd5, 24'h120000, 1'b1, 2'b01, 1'b1}, // R5 lower en, even byte
    '{4'd5, 2'b11, 16'h1203, 16'hF0F4, 3'd5, 24'h120001, 1'b1, 2'b01, 1'b0}, // R5 lower en, odd byte
    '{4'd5, 2'b11, 16'h1203, 16'hF0F4, 3'd5, 24'h120000, 1'b1, 2'b10, 1'b0}, // R5 lower en, word
    '{4'd5, 2'b11, 16'h1203, 16'hF0F8, 3'd5, 24'h120001, 1'b1, 2'b01, 1'b1}, // R5 upper en, odd byte
    '{4'd5, 2'b10, 16'h1203, 16'hF0F8, 3'd5, 24'h120001, 1'b1, 2'b01, 1'b0}, // R5 8-bit ignores lanes
    '{4'd5, 2'b11, 16'h1203, 16'hF0F0, 3'd5, 24'h120000, 1'b1, 2'b10, 1'b1}, // R5 no lane enabled
    '{4'd2, 2'b01, 16'h1203, 16'hF0FC, 3'd5, 24'h120000, 1'b1, 2'b01, 1'b1}, // R2 pin not cs
    '{4'd6, 2'b10, 16'h1203, 16'hF33C, 3'd7, 24'h0FFFF7, 1'b1, 2'b01, 1'b0}, // R6 level 3 == ipl 3
    '{4'd6, 2'b10, 16'h1203, 16'hF33C, 3'd7, 24'h0FFFFB, 1'b1, 2'b01, 1'b1}, // R6 level 5 != ipl 3
    '{4'd6, 2'b10, 16'h1203, 16'hF03C, 3'd7, 24'h0FFFFB, 1'b1, 2'b01, 1'b0}, // R6 ipl 0 any level
    '{4'd6, 2'b10, 16'h1203, 16'hF03C, 3'd7, 24'h020007, 1'b1, 2'b01, 1'b1}, // R6 cpu space not iack
    '{4'd6, 2'b10, 16'h1203, 16'hF03C, 3'd5, 24'h120000, 1'b1, 2'b01, 1'b1}  // R6 cpu field, data fc
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
  endtask

  // R12 register map: 0 base, 1 option, 2 pin configuration
  task automatic prog(input logic [1:0] pin, input logic [15:0] base, input logic [15:0] opt);
    wr(2'd0, base);
    wr(2'd1, opt);
    wr(2'd2, {14'd0, pin});
    @(negedge clk); reg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus(input logic [2:0] f, input logic [23:0] a, input logic r, input logic [1:0] s);
    fc = f; addr = a; rw = r; siz = s;
  endtask

  task automatic as_low();
    @(negedge clk); as_n = 1'b0; #5;
  endtask

  task automatic as_high();
    @(negedge clk); as_n = 1'b1; #5;
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1 reset state
    chk("R1 cs_n", {7'd0, cs_n}, 8'd1);
    chk("R1 dsack_n", {6'd0, dsack_n}, 8'h03);
    chk("R1 avec_n", {7'd0, avec_n}, 8'd1);
    // R1 zeroed registers leave channel disabled even for a base-0 address
    bus(3'd5, 24'h000000, 1'b1, 2'b01);
    as_low();
    chk("R1 cs_n disabled after reset", {7'd0, cs_n}, 8'd1);
    repeat (2) @(negedge clk);
    chk("R1 dsack_n disabled after reset", {6'd0, dsack_n}, 8'h03);
    as_high();

    // table walk: async, external DSACK
    for (int i = 0; i < NVEC; i++) begin
      prog(VECS[i].pin, VECS[i].base, VECS[i].opt);
      bus(VECS[i].fc, VECS[i].addr, VECS[i].rw, VECS[i].siz);
      as_low();
      chk($sformatf("R%0d vec %0d cs_n", VECS[i].req, i), {7'd0, cs_n}, {7'd0, VECS[i].cs_n});
      as_high();
    end

    // R7 strobe select waits for data strobe; negation follows address strobe
    prog(2'b10, 16'h1203, 16'hF0FE);
    bus(3'd5, 24'h120000, 1'b1, 2'b01);
    as_low();
    chk("R7 cs_n before ds", {7'd0, cs_n}, 8'd1);
    @(negedge clk); ds_n = 1'b0; #5;
    chk("R7 cs_n with ds", {7'd0, cs_n}, 8'd0);
    as_high();
    chk("R7 cs_n as negated", {7'd0, cs_n}, 8'd1);
    ds_n = 1'b1;

    // R9 two wait states, 16-bit port
    prog(2'b11, 16'h1203, 16'h20FC);
    bus(3'd5, 24'h120000, 1'b1, 2'b10);
    as_low();
    chk("R9 n=2 at start", {6'd0, dsack_n}, 8'h03);
    @(negedge clk);
    chk("R9 n=2 after 1 edge", {6'd0, dsack_n}, 8'h03);
    @(negedge clk);
    chk("R9 n=2 after 2 edges", {6'd0, dsack_n}, 8'h03);
    @(negedge clk);
    chk("R9 n=2 after 3 edges", {6'd0, dsack_n}, 8'h01);
    as_high();
    chk("R9 negate with as", {6'd0, dsack_n}, 8'h03);
    // R9 counter restarts on next cycle
    as_low();
    chk("R9 restart", {6'd0, dsack_n}, 8'h03);
    as_high();

    // R9 zero wait states
    prog(2'b11, 16'h1203, 16'h00FC);
    as_low();
    chk("R9 n=0 at start", {6'd0, dsack_n}, 8'h03);
    @(negedge clk);
    chk("R9 n=0 after 1 edge", {6'd0, dsack_n}, 8'h01);
    as_high();

    // R9 fast termination on 8-bit port
    prog(2'b10, 16'h1203, 16'hE0FC);
    as_low();
    chk("R9 fast 8-bit", {6'd0, dsack_n}, 8'h02);
    as_high();

    // R9 external: never driven
    prog(2'b11, 16'h1203, 16'hF0FC);
    as_low();
    repeat (20) @(negedge clk);
    chk("R9 external held", {6'd0, dsack_n}, 8'h03);
    chk("R9 external cs", {7'd0, cs_n}, 8'd0);
    as_high();

    // R8 synchronous mode
    eclk = 1'b0;
    prog(2'b11, 16'h1203, 16'h20FD);
    as_low();
    chk("R8 no cs before eclk", {7'd0, cs_n}, 8'd1);
    repeat (3) @(negedge clk);
    chk("R8 still waiting", {7'd0, cs_n}, 8'd1);
    @(negedge clk); eclk = 1'b1; #5;
    chk("R8 not before edge", {7'd0, cs_n}, 8'd1);
    @(negedge clk);
    chk("R8 cs after eclk rise", {7'd0, cs_n}, 8'd0);
    repeat (4) @(negedge clk);
    chk("R8 no internal dsack", {6'd0, dsack_n}, 8'h03);
    as_high();
    chk("R8 negate with as", {7'd0, cs_n}, 8'd1);
    eclk = 1'b0;

    // R10 autovector on interrupt acknowledge
    prog(2'b11, 16'h1203, 16'hE83C);
    bus(3'd7, 24'h0FFFFB, 1'b1, 2'b01);
    as_low();
    chk("R10 avec on iack", {7'd0, avec_n}, 8'd0);
    chk("R10 cs on iack", {7'd0, cs_n}, 8'd0);
    repeat (2) @(negedge clk);
    chk("R10 dsack held", {6'd0, dsack_n}, 8'h03);
    as_high();
    prog(2'b11, 16'h1203, 16'hE8FC);
    bus(3'd5, 24'h120000, 1'b1, 2'b10);
    as_low();
    chk("R10 no avec on data cycle", {7'd0, avec_n}, 8'd1);
    chk("R10 dsack on data cycle", {6'd0, dsack_n}, 8'h01);
    as_high();

    // R11 write during cycle deferred
    prog(2'b10, 16'h1203, 16'hF0FC);
    bus(3'd5, 24'h120000, 1'b1, 2'b01);
    as_low();
    chk("R11 cs before write", {7'd0, cs_n}, 8'd0);
    wr(2'd2, 16'h0000);
    @(negedge clk); reg_we = 1'b0;
    @(negedge clk);
    chk("R11 cs held after mid-cycle write", {7'd0, cs_n}, 8'd0);
    as_high();
    @(negedge clk);
    as_low();
    chk("R11 write active next cycle", {7'd0, cs_n}, 8'd1);
    as_high();

    // R12 select 3 is ignored
    prog(2'b10, 16'h1203, 16'hF0FC);
    wr(2'd3, 16'h0000);
    @(negedge clk); reg_we = 1'b0;
    repeat (2) @(negedge clk);
    as_low();
    chk("R12 select 3 ignored", {7'd0, cs_n}, 8'd0);
    as_high();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule